// File: doc/BRIEF.md
# Shared PWM Generator Bank

The block holds eight waveform generators and a channel table. Each generator has a period word and a pair of slot counts: one for the high phase, one for the low phase. Each output channel reads one nibble from the table. The nibble names the generator the channel follows and says whether the channel is on. Many channels can follow the same generator, so at most eight different period and duty pairs are live at any time. Choosing which channel uses which generator is left to software.

The generators share one base tick. It fires once every `TICK_DIV` clock cycles and stands for 1/255 of a 4 ms period unit. A slot lasts `period` ticks. A full period has as many slots as the high and low counts added together, which is 255 when the low count is written as 255 minus the high count. The first 16 channels drive pins directly. The other 17 feed a serial shift-out stage. Writes to a generator take hold at once. Clearing a channel's enable only takes hold when the generator it follows wraps to the start of a period.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset all outputs are 0. Every generator word and every channel nibble reads as zero, so no channel drives high until it is set up.
- R2: One slot lasts P × TICK_DIV clock cycles, where P is the 8-bit period value. A P of 0 counts as 1.
- R3: A period opens with the high phase and then runs the low phase. When high + low = 255, rising edges on an output are 255 × P × TICK_DIV cycles apart, and the output is high for high × P × TICK_DIV cycles of each period.
- R4: A high count of 255 with a low count of 0 keeps the output high all the time. A high count of 0 keeps it low all the time.
- R5: Write map by word address. Addresses 0–1 hold periods, four generators per word, generator 4a+k in bits 8k+7..8k. Addresses 2–5 hold duty pairs, generator 2a+k in bits 16k+15..16k, with the high count in the low byte and the low count in the high byte. Addresses 6–7 hold nibbles for channels 0–15. Addresses 8–10 hold nibbles for channels 16–32. Channel 8a+k sits in bits 4k+3..4k of its word.
- R6: In a channel nibble, bits 2..0 pick the generator and bit 3 is the enable. Channel c<16 drives dir_out[c]. Channel c≥16 drives ser_out[c−16].
- R7: Setting a channel's enable makes the channel follow its generator from the first cycle after the write.
- R8: Clearing an enable lets the current period of the selected generator run to its end. From the next period on, the channel drives 0.
- R9: A write to a generator changes its running output in the first cycle after the write, and its counters are not restarted.
- R10: Two enabled channels that pick the same generator produce the same waveform, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| dir_out | output | NUM_DIRECT | Levels for the direct pins, channels 0–15 |
| ser_out | output | NUM_SERIAL | Levels for the shift-out stage, channels 16–32 |

## Verification
A write is registered at the clock edge where it is presented. Outputs are combinational from registered state, so an enable or a generator change shows in the first sample after that edge. The bench drives inputs and samples outputs on falling edges, so that first sample is the one it checks. Period-level results do not depend on phase. The bench waits one full period after a configuration write, then counts high samples over a window of exactly one period, and counts the distance between rising edges. For the deferred disable, it lines up on a rising edge of a sibling channel that follows the same generator, so the window covers exactly the period in which the disable arrived.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int GEN_COUNT = 8;
  localparam int GEN_IDX_W = 3;
  localparam int SLOT_W    = 9;   // high + low counts can reach 510

  // one slot spans this many ticks; zero is clamped to one
  function automatic logic [7:0] slot_ticks(input logic [7:0] per);
    return (per == 8'd0) ? 8'd1 : per;
  endfunction

  // number of slots that make up one full period
  function automatic logic [SLOT_W-1:0] period_slots(input logic [7:0] hi, input logic [7:0] lo);
    return {1'b0, hi} + {1'b0, lo};
  endfunction

  // nibble k of a packed 32-bit map word
  function automatic logic [3:0] nib_at(input logic [31:0] w, input int k);
    return w[4*k +: 4];
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      assign tick = (cnt_q == CW'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
      end
      // R2: ticks never come back to back when the divider exceeds one
      a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] per,
  input  logic [7:0] hi_cnt,
  input  logic [7:0] lo_cnt,
  output logic       level,
  output logic       wrap
);
  logic [7:0]        pre_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_end;

  assign slot_end = tick && (({1'b0, pre_q} + 9'd1) >= {1'b0, slot_ticks(per)});
  assign wrap     = slot_end &&
                    (({1'b0, slot_q} + 10'd1) >= {1'b0, period_slots(hi_cnt, lo_cnt)});
  assign level    = (slot_q < {1'b0, hi_cnt});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else begin
      if (tick)     pre_q  <= slot_end ? 8'd0 : pre_q + 8'd1;
      if (slot_end) slot_q <= wrap ? '0 : slot_q + 1'b1;
    end
  end

  // R3: the level only moves at a slot boundary or on a new high count
  a_r3_level_holds_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!slot_end) && $stable(hi_cnt)) |-> $stable(level));
  // R4: a zero high count never yields a high level
  a_r4_zero_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == 8'd0) |-> !level);
  // R3: the slot index stays inside the largest possible period
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < 9'd510);
endmodule

// File: rtl/pwm_chan_mux.sv
module pwm_chan_mux
  import pwm_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           map_nib,
  input  logic [GEN_COUNT-1:0] gen_level,
  input  logic [GEN_COUNT-1:0] gen_wrap,
  output logic                 ch_out
);
  logic [GEN_IDX_W-1:0] sel;
  logic                 en, hold_q, wrap_sel, active;

  assign sel      = map_nib[GEN_IDX_W-1:0];
  assign en       = map_nib[3];
  assign wrap_sel = gen_wrap[sel];
  assign active   = en | hold_q;
  assign ch_out   = active & gen_level[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= 1'b0;
    else if (en)       hold_q <= 1'b1;
    else if (wrap_sel) hold_q <= 1'b0;
  end

  // R8: a channel only goes inactive right after its generator wrapped
  a_r8_release_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(wrap_sel));
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
  import pwm_bank_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int NUM_DIRECT = 16,
  parameter int NUM_SERIAL = 17,
  parameter int ADDR_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [NUM_DIRECT-1:0] dir_out,
  output logic [NUM_SERIAL-1:0] ser_out
);
  localparam int NUM_CH     = NUM_DIRECT + NUM_SERIAL;
  localparam int PER_WORDS  = GEN_COUNT / 4;
  localparam int DUTY_WORDS = GEN_COUNT / 2;
  localparam int DMAP_WORDS = (NUM_DIRECT + 7) / 8;
  localparam int PER_BASE   = 0;
  localparam int DUTY_BASE  = PER_BASE + PER_WORDS;
  localparam int DMAP_BASE  = DUTY_BASE + DUTY_WORDS;
  localparam int SMAP_BASE  = DMAP_BASE + DMAP_WORDS;

  logic [7:0] per_q [GEN_COUNT];
  logic [7:0] hi_q  [GEN_COUNT];
  logic [7:0] lo_q  [GEN_COUNT];
  logic [3:0] map_q [NUM_CH];

  logic                 tick;
  logic [GEN_COUNT-1:0] gen_level, gen_wrap;
  logic [NUM_CH-1:0]    ch_level;
  int                   addr_i;

  assign addr_i = int'(wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GEN_COUNT; g++) begin
        per_q[g] <= '0;
        hi_q[g]  <= '0;
        lo_q[g]  <= '0;
      end
      for (int c = 0; c < NUM_CH; c++) map_q[c] <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < GEN_COUNT; g++) begin
        if (addr_i == PER_BASE + g / 4)
          per_q[g] <= wr_data[8*(g%4) +: 8];
        if (addr_i == DUTY_BASE + g / 2) begin
          hi_q[g] <= wr_data[16*(g%2) +: 8];
          lo_q[g] <= wr_data[16*(g%2) + 8 +: 8];
        end
      end
      for (int c = 0; c < NUM_DIRECT; c++)
        if (addr_i == DMAP_BASE + c / 8) map_q[c] <= nib_at(wr_data, c % 8);
      for (int s = 0; s < NUM_SERIAL; s++)
        if (addr_i == SMAP_BASE + s / 8) map_q[NUM_DIRECT + s] <= nib_at(wr_data, s % 8);
    end
  end

  pwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
      pwm_wave_gen u_gen (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .per(per_q[g]), .hi_cnt(hi_q[g]), .lo_cnt(lo_q[g]),
        .level(gen_level[g]), .wrap(gen_wrap[g])
      );
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pwm_chan_mux u_ch (
        .clk(clk), .rst_n(rst_n), .map_nib(map_q[c]),
        .gen_level(gen_level), .gen_wrap(gen_wrap), .ch_out(ch_level[c])
      );
    end
  endgenerate

  assign dir_out = ch_level[NUM_DIRECT-1:0];
  assign ser_out = ch_level[NUM_CH-1:NUM_DIRECT];
endmodule

// File: tb/pwm_bank_top_tb.sv
module pwm_bank_top_tb;
  localparam int TD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] dir_out;
  logic [16:0] ser_out;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] sh_per [8];
  logic [7:0] sh_hi  [8];
  logic [7:0] sh_lo  [8];
  logic [3:0] sh_map [33];

  // {generator, period, high count, channel}
  localparam int VEC [6][4] = '{
    '{0, 1, 128, 0}, '{3, 2, 1, 5}, '{5, 3, 200, 20},
    '{7, 0, 64, 32}, '{2, 1, 255, 15}, '{6, 2, 0, 16}};

  always #5 clk = ~clk;

  pwm_bank_top #(.TICK_DIV(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dir_out(dir_out), .ser_out(ser_out));

  function automatic logic chan_out(input int c);
    return (c < 16) ? dir_out[c] : ser_out[c-16];
  endfunction

  function automatic int plen(input int p);
    return 255 * ((p == 0) ? 1 : p) * TD;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_gen(input int g, input int p, input int hi, input int lo);
    int b;
    sh_per[g] = 8'(p); sh_hi[g] = 8'(hi); sh_lo[g] = 8'(lo);
    b = (g / 4) * 4;
    wr(g / 4, {sh_per[b+3], sh_per[b+2], sh_per[b+1], sh_per[b]});
    b = (g / 2) * 2;
    wr(2 + g / 2, {sh_lo[b+1], sh_hi[b+1], sh_lo[b], sh_hi[b]});
  endtask

  function automatic logic [31:0] map_word(input int c);
    logic [31:0] w = '0;
    int first = (c < 16) ? (c / 8) * 8 : 16 + ((c - 16) / 8) * 8;
    for (int k = 0; k < 8; k++)
      if (first + k < 33 && ((c < 16) == (first + k < 16))) w[4*k +: 4] = sh_map[first + k];
    return w;
  endfunction

  function automatic int map_addr(input int c);
    return (c < 16) ? 6 + c / 8 : 8 + (c - 16) / 8;
  endfunction

  task automatic set_map(input int c, input logic [3:0] nib);
    sh_map[c] = nib;
    wr(map_addr(c), map_word(c));
  endtask

  task automatic count_high(input int c, input int len, output int n);
    n = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      n += int'(chan_out(c));
    end
  endtask

  task automatic wait_rise(input int c, input int lim, output int waited);
    logic prev = chan_out(c);
    waited = 0;
    while (waited < lim) begin
      @(negedge clk);
      waited++;
      if (!prev && chan_out(c)) break;
      prev = chan_out(c);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, w, pl;
    for (int g = 0; g < 8; g++) begin sh_per[g] = '0; sh_hi[g] = '0; sh_lo[g] = '0; end
    for (int c = 0; c < 33; c++) sh_map[c] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 reset outputs", int'({dir_out, ser_out} != 0), 0);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      n += int'({dir_out, ser_out} != 0);
    end
    check("R1 idle after reset", n, 0);

    // R2 R3 R4 R5 R6: vector walk
    for (int v = 0; v < 6; v++) begin
      pl = plen(VEC[v][1]);
      set_gen(VEC[v][0], VEC[v][1], VEC[v][2], 255 - VEC[v][2]);
      set_map(VEC[v][3], {1'b1, 3'(VEC[v][0])});
      repeat (pl) @(negedge clk);
      count_high(VEC[v][3], pl, n);
      check($sformatf("R3 R4 R6 high count vec%0d", v), n, VEC[v][2] * (pl / 255));
      if (VEC[v][2] > 0 && VEC[v][2] < 255) begin
        wait_rise(VEC[v][3], 2 * pl, w);
        wait_rise(VEC[v][3], 2 * pl, w);
        check($sformatf("R2 R5 period vec%0d", v), w, pl);
      end
    end
    check("R6 unmapped channel low", int'(dir_out[1]), 0);

    // R7: enable takes hold in the first cycle after the write
    set_gen(4, 1, 255, 0);
    check("R7 before enable", int'(dir_out[10]), 0);
    set_map(10, 4'b1100);
    check("R7 enable immediate", int'(dir_out[10]), 1);

    // R9: generator change shows at once
    set_gen(4, 1, 0, 255);
    check("R9 generator change immediate", int'(dir_out[10]), 0);

    // R10: two channels on one generator match
    set_map(3, 4'b1101);
    pl = plen(3);
    repeat (pl) @(negedge clk);
    n = 0;
    for (int k = 0; k < pl; k++) begin
      @(negedge clk);
      n += int'(dir_out[3] != ser_out[4]);
    end
    check("R10 shared generator mismatches", n, 0);

    // R8: disable deferred to the period end
    set_gen(1, 1, 128, 127);
    set_map(8, 4'b1001);
    set_map(9, 4'b1001);
    pl = plen(1);
    repeat (pl) @(negedge clk);
    wait_rise(9, 2 * pl, w);
    n = int'(dir_out[8]);
    sh_map[8] = 4'b0001;
    wr_en = 1'b1; wr_addr = 4'(map_addr(8)); wr_data = map_word(8);
    for (int k = 1; k < pl; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      n += int'(dir_out[8]);
    end
    check("R8 high phase kept after disable", n, 128 * TD);
    @(negedge clk);
    check("R8 sibling wraps on schedule", int'(dir_out[9]), 1);
    n = int'(dir_out[8]);
    for (int k = 1; k < pl; k++) begin
      @(negedge clk);
      n += int'(dir_out[8]);
    end
    check("R8 low after period end", n, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule